// File: doc/BRIEF.md
# NAND Page Read Controller

This block is the host side of a read path to a small-page NAND flash with an 8-bit shared I/O bus. A request names a region of the page (lower half of the main area, upper half of the main area, or the 16-byte spare area), a starting column, a 16-bit row and a byte count. The block drives chip enable and puts a read command byte on the bus with the command latch strobe. It then sends three address bytes with the address latch strobe, each latched by a write strobe pulse. It waits for the ready/busy line to report the page as loaded. After that it pulses the read strobe once per byte and hands each byte to a valid/ready output stream.

When the stream runs past the last byte of a page, the flash moves on to the next row by itself. The controller keeps chip enable low, waits for ready/busy again and carries on reading, so one request can span several pages. The read command is left out when the flash's internal region pointer already selects the requested region. The read strobe timing and the ready/busy timeout are set through configuration inputs counted in clock cycles. A timeout ends the transaction and raises an error flag.

Top module: `nand_rd_ctrl`

## Requirements
- R1: During and directly after reset, `nand_ce_n`, `nand_we_n` and `nand_re_n` are 1; `nand_cle`, `nand_ale`, `nand_io_oe`, `out_valid` and `err_timeout` are 0; and `req_ready` is 1.
- R2: When a read command is needed, it is sent first as one bus cycle with `nand_cle`=1 and `nand_ale`=0, latched by a rising `nand_we_n`. The command byte is 00h for region 0 (main lower half), 01h for region 1 (main upper half) and 50h for region 2 (spare). `req_region` value 3 is treated as region 2.
- R3: Three address cycles follow, each with `nand_ale`=1 and `nand_cle`=0 and each latched by a rising `nand_we_n`. The bytes are sent in this order: column, row bits 7..0, row bits 15..8. The command and address latch strobes are never high together.
- R4: The command cycle is left out when the requested region equals the tracked pointer. The pointer is region 0 after reset. A spare request sets it to region 2. A region 0 request sets it to region 0. A region 1 request always sends 01h and leaves the pointer at region 0.
- R5: After the address cycles, no read strobe pulse begins until `nand_rb` has been seen low and then high.
- R6: Each read strobe low phase lasts max(`cfg_re_low`,1) cycles. Each high phase lasts at least max(`cfg_re_high`,1) cycles. The byte is taken from `nand_io_in` in the last low cycle.
- R7: Exactly `req_len` bytes (at least 1) are delivered in column order. The first byte is at page offset `req_col` for region 0, 256+`req_col` for region 1, and 512+`req_col[3:0]` for region 2.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold. No read strobe pulse starts while `out_valid` is 1.
- R9: After the byte at page offset 527, if bytes remain, the controller waits for `nand_rb` low-then-high again without further command or address cycles. It then continues at the next row (row+1, modulo 2^16) from offset 0 for regions 0 and 1, or from offset 512 for the spare region.
- R10: After the last byte, `nand_ce_n` returns to 1 and `req_ready` returns to 1.
- R11: If a ready/busy wait lasts `cfg_timeout` cycles, `err_timeout` is set, `nand_ce_n` is raised and the request ends. `err_timeout` clears when the next request is accepted.
- R12: `nand_ce_n` is 0 in every cycle in which `nand_we_n` or `nand_re_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken this cycle if valid |
| req_region | input | 2 | Region: 0 main lower, 1 main upper, 2/3 spare |
| req_col | input | 8 | Starting column within the region |
| req_row | input | 16 | Starting row (page) address |
| req_len | input | LEN_W | Number of bytes to read, at least 1 |
| cfg_re_low | input | TW_W | Read strobe low phase, cycles (0 acts as 1) |
| cfg_re_high | input | TW_W | Read strobe high phase, cycles (0 acts as 1) |
| cfg_timeout | input | TMO_W | Ready/busy wait limit, cycles |
| out_valid | output | 1 | Output byte available |
| out_ready | input | 1 | Consumer accepts the byte |
| out_data | output | 8 | Output byte |
| err_timeout | output | 1 | Last request ended on a ready/busy timeout |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | Bus byte driven toward the flash |
| nand_io_oe | output | 1 | Drive enable for `nand_io_out` |
| nand_io_in | input | 8 | Bus byte returned by the flash |
| nand_rb | input | 1 | Ready/busy, high when ready |

## Verification
The assertions assume a well-formed request: a nonzero byte count, and configuration inputs that do not change while a request is in flight. They also assume a flash that pulls ready/busy low soon after the last address byte and after the read strobe that leaves offset 527, then releases it. The bench keeps to these rules. It changes configuration only while the controller is idle. Its flash model drops ready/busy two cycles after each trigger and holds it low for a fixed load time. The one exception is a deliberately stuck case used to provoke the timeout. The consumer's ready signal is driven from a shift-register pattern so that stalls land on arbitrary bytes, page crossings included.

// File: rtl/nand_rd_pkg.sv
package nand_rd_pkg;

    localparam int COL_W      = 8;
    localparam int ROW_W      = 16;
    localparam int OFF_W      = 10;
    localparam int ADDR_BYTES = 3;

    localparam logic [OFF_W-1:0] PAGE_LAST  = 10'd527;
    localparam logic [OFF_W-1:0] SPARE_BASE = 10'd512;

    localparam logic [7:0] OP_MAIN_LO = 8'h00;
    localparam logic [7:0] OP_MAIN_HI = 8'h01;
    localparam logic [7:0] OP_SPARE   = 8'h50;

    typedef enum logic [1:0] {
        RG_MAIN_LO = 2'd0,
        RG_MAIN_HI = 2'd1,
        RG_SPARE   = 2'd2
    } region_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_WAIT,
        ST_READ
    } seq_e;

    typedef enum logic [1:0] {
        SP_IDLE,
        SP_LOW,
        SP_HIGH
    } strobe_e;

    typedef enum logic [1:0] {
        WB_IDLE,
        WB_SEEK_LOW,
        WB_SEEK_HIGH
    } rbwait_e;

    function automatic region_e norm_region(input logic [1:0] code);
        case (code)
            2'd0:    return RG_MAIN_LO;
            2'd1:    return RG_MAIN_HI;
            default: return RG_SPARE;
        endcase
    endfunction

    function automatic logic [7:0] op_of(input region_e rg);
        case (rg)
            RG_MAIN_LO: return OP_MAIN_LO;
            RG_MAIN_HI: return OP_MAIN_HI;
            default:    return OP_SPARE;
        endcase
    endfunction

    function automatic logic [OFF_W-1:0] first_off(input region_e rg, input logic [COL_W-1:0] col);
        case (rg)
            RG_MAIN_LO: return {2'b00, col};
            RG_MAIN_HI: return {2'b01, col};
            default:    return SPARE_BASE | {6'd0, col[3:0]};
        endcase
    endfunction

    function automatic logic [OFF_W-1:0] wrap_off(input region_e rg);
        return (rg == RG_SPARE) ? SPARE_BASE : '0;
    endfunction

endpackage

// File: rtl/nand_rd_strobe.sv
module nand_rd_strobe
    import nand_rd_pkg::*;
#(
    parameter int TW_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            go,
    input  logic [TW_W-1:0] low_cyc,
    input  logic [TW_W-1:0] high_cyc,
    output logic            re_n,
    output logic            sample,
    output logic            busy
);
    strobe_e         ph;
    logic [TW_W-1:0] cnt;

    function automatic logic [TW_W-1:0] span(input logic [TW_W-1:0] n);
        return (n == '0) ? '0 : n - 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            ph   <= SP_IDLE;
            re_n <= 1'b1;
            cnt  <= '0;
        end else begin
            case (ph)
                SP_IDLE: if (go) begin
                    ph   <= SP_LOW;
                    re_n <= 1'b0;
                    cnt  <= span(low_cyc);
                end
                SP_LOW: if (cnt == '0) begin
                    ph   <= SP_HIGH;
                    re_n <= 1'b1;
                    cnt  <= span(high_cyc);
                end else begin
                    cnt <= cnt - 1'b1;
                end
                SP_HIGH: if (cnt == '0) begin
                    ph <= SP_IDLE;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                default: ph <= SP_IDLE;
            endcase
        end
    end

    assign sample = (ph == SP_LOW) && (cnt == '0);
    assign busy   = (ph != SP_IDLE);
endmodule

// File: rtl/nand_rd_rbwait.sv
module nand_rd_rbwait
    import nand_rd_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic             rb,
    input  logic [TMO_W-1:0] limit,
    output logic             done,
    output logic             expired
);
    rbwait_e          ph;
    logic [TMO_W-1:0] cnt;

    assign done    = (ph == WB_SEEK_HIGH) && rb;
    assign expired = (ph != WB_IDLE) && !done && (cnt >= limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph  <= WB_IDLE;
            cnt <= '0;
        end else begin
            case (ph)
                WB_IDLE: if (go) begin
                    ph  <= WB_SEEK_LOW;
                    cnt <= '0;
                end
                WB_SEEK_LOW, WB_SEEK_HIGH: begin
                    if (done || expired) begin
                        ph <= WB_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                        if (ph == WB_SEEK_LOW && !rb) ph <= WB_SEEK_HIGH;
                    end
                end
                default: ph <= WB_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/nand_rd_ctrl.sv
module nand_rd_ctrl
    import nand_rd_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int TW_W  = 4,
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_region,
    input  logic [7:0]       req_col,
    input  logic [15:0]      req_row,
    input  logic [LEN_W-1:0] req_len,
    input  logic [TW_W-1:0]  cfg_re_low,
    input  logic [TW_W-1:0]  cfg_re_high,
    input  logic [TMO_W-1:0] cfg_timeout,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_data,
    output logic             err_timeout,
    output logic             nand_ce_n,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic [7:0]       nand_io_out,
    output logic             nand_io_oe,
    input  logic [7:0]       nand_io_in,
    input  logic             nand_rb
);
    localparam logic [LEN_W-1:0] LEN_ONE   = LEN_W'(1);
    localparam logic [1:0]       ADDR_LAST = 2'(ADDR_BYTES - 1);

    seq_e             st;
    region_e          ptr;
    region_e          cur_rg;
    region_e          req_rg;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic [OFF_W-1:0] off;
    logic [LEN_W-1:0] left;
    logic             half;
    logic [1:0]       aidx;
    logic             page_end;
    logic             re_go, re_sample, re_busy;
    logic             wt_go, wt_done, wt_expired;

    assign req_rg    = norm_region(req_region);
    assign req_ready = (st == ST_IDLE);
    assign page_end  = (off == PAGE_LAST);
    assign re_go     = (st == ST_READ) && !re_busy && !out_valid && (left != '0);
    assign wt_go     = (st == ST_ADDR && half && aidx == ADDR_LAST)
                     || (re_sample && page_end && left != LEN_ONE);

    nand_rd_strobe #(.TW_W(TW_W)) u_strobe (
        .clk      (clk),
        .rst      (rst),
        .go       (re_go),
        .low_cyc  (cfg_re_low),
        .high_cyc (cfg_re_high),
        .re_n     (nand_re_n),
        .sample   (re_sample),
        .busy     (re_busy)
    );

    nand_rd_rbwait #(.TMO_W(TMO_W)) u_rbwait (
        .clk     (clk),
        .rst     (rst),
        .go      (wt_go),
        .rb      (nand_rb),
        .limit   (cfg_timeout),
        .done    (wt_done),
        .expired (wt_expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            ptr         <= RG_MAIN_LO;
            cur_rg      <= RG_MAIN_LO;
            row_q       <= '0;
            col_q       <= '0;
            off         <= '0;
            left        <= '0;
            half        <= 1'b0;
            aidx        <= '0;
            nand_ce_n   <= 1'b1;
            nand_cle    <= 1'b0;
            nand_ale    <= 1'b0;
            nand_we_n   <= 1'b1;
            nand_io_out <= '0;
            nand_io_oe  <= 1'b0;
            err_timeout <= 1'b0;
            out_valid   <= 1'b0;
            out_data    <= '0;
        end else begin
            if (re_sample) begin
                out_valid <= 1'b1;
                out_data  <= nand_io_in;
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end

            case (st)
                ST_IDLE: if (req_valid) begin
                    err_timeout <= 1'b0;
                    cur_rg      <= req_rg;
                    row_q       <= req_row;
                    col_q       <= req_col;
                    left        <= req_len;
                    off         <= first_off(req_rg, req_col);
                    ptr         <= (req_rg == RG_MAIN_HI) ? RG_MAIN_LO : req_rg;
                    nand_ce_n   <= 1'b0;
                    nand_io_oe  <= 1'b1;
                    nand_we_n   <= 1'b0;
                    half        <= 1'b0;
                    aidx        <= '0;
                    if (req_rg != ptr) begin
                        st          <= ST_CMD;
                        nand_cle    <= 1'b1;
                        nand_io_out <= op_of(req_rg);
                    end else begin
                        st          <= ST_ADDR;
                        nand_ale    <= 1'b1;
                        nand_io_out <= req_col;
                    end
                end
                ST_CMD: if (!half) begin
                    nand_we_n <= 1'b1;
                    half      <= 1'b1;
                end else begin
                    nand_cle    <= 1'b0;
                    nand_ale    <= 1'b1;
                    nand_we_n   <= 1'b0;
                    nand_io_out <= col_q;
                    half        <= 1'b0;
                    st          <= ST_ADDR;
                end
                ST_ADDR: if (!half) begin
                    nand_we_n <= 1'b1;
                    half      <= 1'b1;
                end else if (aidx == ADDR_LAST) begin
                    nand_ale   <= 1'b0;
                    nand_io_oe <= 1'b0;
                    st         <= ST_WAIT;
                end else begin
                    aidx        <= aidx + 1'b1;
                    nand_we_n   <= 1'b0;
                    half        <= 1'b0;
                    nand_io_out <= (aidx == '0) ? row_q[7:0] : row_q[15:8];
                end
                ST_WAIT: if (wt_done) begin
                    st <= ST_READ;
                end else if (wt_expired) begin
                    err_timeout <= 1'b1;
                    nand_ce_n   <= 1'b1;
                    st          <= ST_IDLE;
                end
                ST_READ: if (re_sample) begin
                    left <= left - 1'b1;
                    if (page_end) begin
                        off   <= wrap_off(cur_rg);
                        row_q <= row_q + 1'b1;
                        if (left != LEN_ONE) st <= ST_WAIT;
                    end else begin
                        off <= off + 1'b1;
                    end
                end else if (left == '0 && !re_busy) begin
                    nand_ce_n <= 1'b1;
                    st        <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/nand_rd_ctrl_chk.sv
module nand_rd_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       err_timeout,
    input logic       nand_ce_n,
    input logic       nand_cle,
    input logic       nand_ale,
    input logic       nand_we_n,
    input logic       nand_re_n,
    input logic       nand_io_oe
);
    assert_latch_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
        !(nand_cle && nand_ale));

    assert_latch_drives_bus_R2: assert property (@(posedge clk) disable iff (rst)
        (nand_cle || nand_ale) |-> nand_io_oe);

    assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_no_pulse_when_full_R8: assert property (@(posedge clk) disable iff (rst)
        !nand_re_n |-> !out_valid);

    assert_idle_releases_ce_R10: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> nand_ce_n);

    assert_timeout_ends_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(err_timeout) |-> (nand_ce_n && req_ready));

    assert_ce_during_strobe_R12: assert property (@(posedge clk) disable iff (rst)
        (!nand_we_n || !nand_re_n) |-> !nand_ce_n);
endmodule

bind nand_rd_ctrl nand_rd_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_ready   (req_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .err_timeout (err_timeout),
    .nand_ce_n   (nand_ce_n),
    .nand_cle    (nand_cle),
    .nand_ale    (nand_ale),
    .nand_we_n   (nand_we_n),
    .nand_re_n   (nand_re_n),
    .nand_io_oe  (nand_io_oe)
);

// File: tb/sim_nand_rd_ctrl.sv
module sim_nand_rd_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W = 16;
    localparam int TW_W  = 4;
    localparam int TMO_W = 16;
    localparam int TLOAD = 12;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [1:0]       req_region = '0;
    logic [7:0]       req_col = '0;
    logic [15:0]      req_row = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic [TW_W-1:0]  cfg_re_low = 4'd2;
    logic [TW_W-1:0]  cfg_re_high = 4'd1;
    logic [TMO_W-1:0] cfg_timeout = 16'd200;
    logic             out_valid;
    logic             out_ready = 1'b1;
    logic [7:0]       out_data;
    logic             err_timeout;
    logic             nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
    logic [7:0]       nand_io_out;
    logic [7:0]       nand_io_in;
    logic             nand_rb;

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_rd_ctrl #(.LEN_W(LEN_W), .TW_W(TW_W), .TMO_W(TMO_W)) u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_region(req_region),
        .req_col(req_col), .req_row(req_row), .req_len(req_len),
        .cfg_re_low(cfg_re_low), .cfg_re_high(cfg_re_high), .cfg_timeout(cfg_timeout),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .err_timeout(err_timeout),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_io_out(nand_io_out),
        .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in), .nand_rb(nand_rb)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input logic [15:0] r, input int o);
        logic [7:0] lo = 8'(o);
        logic [7:0] hi = 8'(o >>> 8);
        return (r[7:0] * 8'd5) ^ r[15:8] ^ lo ^ (hi << 6);
    endfunction

    // behavioural flash
    int         f_ptr = 0;
    int         f_off = 0;
    logic [15:0] f_row = '0;
    int         f_bcnt = 0;
    bit         f_loaded = 0;
    bit         f_stuck = 0;
    int         f_ncmd = 0;
    logic [7:0] f_cmd = '0;
    int         f_naddr = 0;
    logic [7:0] f_addr [3];
    logic       p_we = 1'b1, p_re = 1'b1, p_ce = 1'b1;
    int         lo_run = 0, hi_run = 0;

    assign nand_rb    = f_stuck ? 1'b0 : !(f_bcnt > 0 && f_bcnt <= TLOAD);
    assign nand_io_in = pat(f_row, f_off);

    always @(negedge clk) begin
        if (!rst) begin
            int exp_lo;
            int exp_hi;
            exp_lo = (cfg_re_low == 0) ? 1 : int'(cfg_re_low);
            exp_hi = (cfg_re_high == 0) ? 1 : int'(cfg_re_high);
            if (f_bcnt > 0) begin
                f_bcnt--;
                if (f_bcnt == 0) f_loaded = 1;
            end
            if (p_ce && !nand_ce_n) begin
                f_ncmd  = 0;
                f_naddr = 0;
            end
            if (!p_we && nand_we_n) begin
                if (nand_cle) begin
                    f_ncmd++;
                    f_cmd = nand_io_out;
                    f_naddr = 0;
                    f_ptr = (nand_io_out == 8'h50) ? 2 : (nand_io_out == 8'h01) ? 1 : 0;
                end else if (nand_ale) begin
                    if (f_naddr < 3) f_addr[f_naddr] = nand_io_out;
                    f_naddr++;
                    if (f_naddr == 3) begin
                        f_row = {f_addr[2], f_addr[1]};
                        f_off = (f_ptr == 2) ? 512 + int'(f_addr[0][3:0])
                                             : f_ptr * 256 + int'(f_addr[0]);
                        if (f_ptr == 1) f_ptr = 0;
                        f_bcnt = TLOAD + 2;
                        f_loaded = 0;
                    end
                end
            end
            if (p_re && !nand_re_n) begin
                chk(f_loaded, "R5", "read strobe before page loaded", 0, 1);
                chk(hi_run >= exp_hi, "R6", "read strobe high width", hi_run, exp_hi);
                lo_run = 0;
            end
            if (!p_re && nand_re_n) begin
                chk(lo_run == exp_lo, "R6", "read strobe low width", lo_run, exp_lo);
                hi_run = 0;
                f_off++;
                if (f_off == 528) begin
                    f_row++;
                    f_off = (f_ptr == 2) ? 512 : 0;
                    f_bcnt = TLOAD + 2;
                    f_loaded = 0;
                end
            end
            if (!nand_re_n) lo_run++;
            else hi_run++;
            if (!nand_we_n || !nand_re_n)
                chk(!nand_ce_n, "R12", "chip enable during strobe", nand_ce_n, 0);
            p_we = nand_we_n;
            p_re = nand_re_n;
            p_ce = nand_ce_n;
        end
    end

    // reference stream and consumer
    logic [7:0] exp_q [$];
    string      cur_tag = "R7";
    bit         stall_on = 0;
    logic [7:0] lfsr = 8'hA5;
    bit         hold_prev = 0;
    logic [7:0] hold_data = '0;

    always @(negedge clk) begin
        if (!rst) begin
            if (stall_on) begin
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                out_ready = lfsr[0];
            end else begin
                out_ready = 1'b1;
            end
            if (hold_prev)
                chk(out_valid && out_data == hold_data, "R8", "byte held under stall",
                    int'(out_data), int'(hold_data));
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(0, cur_tag, "unexpected extra byte", int'(out_data), 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(out_data == e, cur_tag, "stream byte", int'(out_data), int'(e));
                end
            end
            hold_prev = out_valid && !out_ready;
            hold_data = out_data;
        end
    end

    int bptr = 0;

    task automatic issue(input int rg, input int col, input logic [15:0] row, input int len,
                         input string tag, input bit tmo);
        int   nrg;
        int   off;
        bit   need;
        logic [15:0] rw;
        logic [7:0]  op;
        nrg  = (rg >= 2) ? 2 : rg;
        need = (nrg != bptr);
        bptr = (nrg == 1) ? 0 : nrg;
        op   = (nrg == 2) ? 8'h50 : 8'(nrg);
        off  = (nrg == 2) ? 512 + (col & 15) : nrg * 256 + col;
        rw   = row;
        if (!tmo) begin
            for (int i = 0; i < len; i++) begin
                exp_q.push_back(pat(rw, off));
                off++;
                if (off == 528) begin
                    rw++;
                    off = (nrg == 2) ? 512 : 0;
                end
            end
        end
        cur_tag = tag;
        while (!req_ready) @(negedge clk);
        req_valid  = 1'b1;
        req_region = 2'(rg);
        req_col    = 8'(col);
        req_row    = row;
        req_len    = LEN_W'(len);
        @(negedge clk);
        req_valid = 1'b0;
        chk(err_timeout == 0, "R11", "error cleared on accept", err_timeout, 0);
        if (tmo) begin
            while (!req_ready) @(negedge clk);
            chk(err_timeout == 1, "R11", "timeout flag", err_timeout, 1);
            chk(nand_ce_n == 1, "R11", "chip enable released on timeout", nand_ce_n, 1);
            chk(out_valid == 0, "R11", "no data on timeout", out_valid, 0);
        end else begin
            while (!(req_ready && exp_q.size() == 0 && !out_valid)) @(negedge clk);
            chk(nand_ce_n == 1, "R10", "chip enable released at end", nand_ce_n, 1);
        end
        if (need) begin
            chk(f_ncmd == 1, "R2", "command cycles", f_ncmd, 1);
            chk(f_cmd == op, "R2", "command byte", int'(f_cmd), int'(op));
        end else begin
            chk(f_ncmd == 0, "R4", "command skipped", f_ncmd, 0);
        end
        chk(f_naddr == 3, "R3", "address cycles", f_naddr, 3);
        chk(f_addr[0] == 8'(col), "R3", "address byte 0", int'(f_addr[0]), col);
        chk(f_addr[1] == row[7:0], "R3", "address byte 1", int'(f_addr[1]), int'(row[7:0]));
        chk(f_addr[2] == row[15:8], "R3", "address byte 2", int'(f_addr[2]), int'(row[15:8]));
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(nand_ce_n == 1 && nand_we_n == 1 && nand_re_n == 1, "R1", "strobes idle in reset",
            {nand_ce_n, nand_we_n, nand_re_n}, 3'b111);
        chk(!nand_cle && !nand_ale && !nand_io_oe, "R1", "latches low in reset",
            {nand_cle, nand_ale, nand_io_oe}, 0);
        chk(!out_valid && !err_timeout && req_ready, "R1", "stream idle in reset",
            {out_valid, err_timeout, req_ready}, 1);
        rst = 1'b0;
        @(negedge clk);
        chk(nand_ce_n == 1 && req_ready == 1, "R1", "idle after reset", {nand_ce_n, req_ready}, 3);

        issue(0, 5, 16'h0010, 8, "R7", 0);          // R4: pointer defaults to region 0
        issue(1, 250, 16'h0123, 30, "R9", 0);       // upper half, crosses page end
        issue(0, 0, 16'h0002, 4, "R4", 0);          // pointer back at region 0
        issue(2, 3, 16'h0A00, 30, "R9", 0);         // spare, two page crossings
        issue(3, 15, 16'h0B00, 1, "R9", 0);         // spare alias, ends at offset 527
        stall_on    = 1;
        cfg_re_low  = 4'd0;
        cfg_re_high = 4'd3;
        issue(0, 100, 16'h0007, 40, "R8", 0);       // command 00h after spare, stalls
        cfg_timeout = 16'd20;
        f_stuck     = 1;
        issue(1, 0, 16'h0009, 4, "R11", 1);         // ready never returns
        f_stuck     = 0;
        cfg_timeout = 16'd200;
        issue(0, 255, 16'hFFFF, 275, "R9", 0);      // row wraps, error cleared
        repeat (4) @(negedge clk);
        summary();
        $finish;
    end
endmodule